// File: doc/BRIEF.md
# Dual-Set Pattern Bank Address Generator

This block turns a 13-bit video pattern fetch address into a physical pattern-memory address. It keeps two separate groups of bank registers: eight for sprites and four for background. A shared two-bit mode picks the page size, which is 8 KB, 4 KB, 2 KB or 1 KB. The physical address is the selected bank number times the page size, plus the offset within the page. It is computed combinationally from the registered state.

The host CPU loads the bank registers, the mode, the upper bank bits and the tall-sprite flag through a simple write port. A scanline tracker outside this block supplies the horizontal fetch position and an in-frame flag. These two inputs decide which register group serves each fetch. When tall sprites are on during a frame, the fetch phase decides. In every other case, the group written most recently decides.

Top module: `pattern_bank_gen`

## Requirements
- R1: After reset every register is zero, so the output equals the fetch address zero-extended to 23 bits.
- R2: A bank register write stores {upper bits, 8-bit data}, where the upper bits are the value held at write time. The upper bits are written at 0x5130 (data bits 1:0). A later change to the upper bits leaves stored banks unchanged.
- R3: Sprite group, mode 0: the output is sprite bank 7 × 0x2000 + fetch[12:0].
- R4: Sprite group, mode 1: the output is sprite bank (fetch/0x1000)*4+3 × 0x1000 + fetch[11:0].
- R5: Sprite group, mode 2: the output is sprite bank (fetch/0x800)*2+1 × 0x800 + fetch[10:0].
- R6: Sprite group, mode 3: the output is sprite bank fetch/0x400 × 0x400 + fetch[9:0].
- R7: Background group, modes 0 and 1: the fetch address is first reduced to its low 12 bits. Both modes use background bank 3, multiplied by 0x2000 in mode 0 and by 0x1000 in mode 1, plus the 12-bit offset.
- R8: Background group, modes 2 and 3: the fetch address is reduced to 12 bits, then banks are indexed as for sprites: (f/0x800)*2+1 with 0x800 pages, or f/0x400 with 0x400 pages.
- R9: A write to a sprite bank register (0x5120..0x5127) selects the sprite group. A write to a background bank register (0x5128..0x512B) selects the background group. Out of frame, this last-written choice alone picks the group.
- R10: In frame with tall sprites on, the background group serves fetches whose horizontal position is below 256 or at least 320. The sprite group serves positions 256..319.
- R11: In frame with tall sprites off, the last-written choice picks the group.
- R12: The tall-sprite flag is bit 5 of a write to 0x2000. Other data bits, and writes to unmapped addresses, change nothing.
- R13: The mode is bits 1:0 of a write to 0x5101 (0 = 8 KB, 1 = 4 KB, 2 = 2 KB, 3 = 1 KB). Upper data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| fetch_addr_i | input | 13 | Pattern fetch address |
| hpos_i | input | 9 | Horizontal fetch position of the current line |
| in_frame_i | input | 1 | High while the display is rendering |
| phys_addr_o | output | 23 | Physical pattern-memory address |

## Verification
The assertions assume that writes are sampled at the rising edge. They also assume that the horizontal position lies within a line (0..340), and they treat the in-frame flag as the tracker's word on whether fetch phase matters. The stimulus changes all inputs on the falling edge. It keeps the write strobe low during every comparison cycle, so no register moves between stimulus and sample. It sweeps positions only at the window edges 255, 256, 319 and 320 and at values inside one line.

// File: rtl/pbg_pkg.sv
`timescale 1ns/1ps
package pbg_pkg;
  parameter int FETCH_W   = 13;
  parameter int BANK_LO_W = 8;
  parameter int BANK_HI_W = 2;
  parameter int BANK_W    = BANK_HI_W + BANK_LO_W;
  parameter int PHYS_W    = BANK_W + FETCH_W;
  parameter int SPR_N     = 8;
  parameter int BG_N      = 4;
  parameter int CPU_AW    = 16;
  parameter int CPU_DW    = 8;
  parameter int HPOS_W    = 9;
  parameter int BG_FOLD_W = 12;

  // Sprite-phase window inside a line
  parameter int SPR_PH_LO = 256;
  parameter int SPR_PH_HI = 320;

  parameter logic [CPU_AW-1:0] A_VCTL    = 16'h2000;
  parameter logic [CPU_AW-1:0] A_MODE    = 16'h5101;
  parameter logic [CPU_AW-1:0] A_SPR     = 16'h5120;
  parameter logic [CPU_AW-1:0] A_BG      = 16'h5128;
  parameter logic [CPU_AW-1:0] A_HI      = 16'h5130;
  parameter int                TALL_BIT  = 5;

  typedef enum logic [1:0] {PG_8K = 2'd0, PG_4K = 2'd1, PG_2K = 2'd2, PG_1K = 2'd3} page_mode_e;
endpackage

// File: rtl/pbg_regs.sv
`timescale 1ns/1ps
module pbg_regs
  import pbg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CPU_AW-1:0]   wr_addr_i,
  input  logic [CPU_DW-1:0]   wr_data_i,
  output logic [BANK_W-1:0]   spr_bank_o [SPR_N],
  output logic [BANK_W-1:0]   bg_bank_o  [BG_N],
  output page_mode_e          mode_o,
  output logic                bg_last_o,
  output logic                tall_o
);
  localparam int SPR_LSB = $clog2(SPR_N);
  localparam int BG_LSB  = $clog2(BG_N);

  logic [BANK_HI_W-1:0] hi_q;
  logic                 spr_hit, bg_hit;

  assign spr_hit = wr_en_i && (wr_addr_i[CPU_AW-1:SPR_LSB] == A_SPR[CPU_AW-1:SPR_LSB]);
  assign bg_hit  = wr_en_i && (wr_addr_i[CPU_AW-1:BG_LSB]  == A_BG[CPU_AW-1:BG_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      mode_o    <= PG_8K;
      tall_o    <= 1'b0;
      bg_last_o <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_HI)   hi_q   <= wr_data_i[BANK_HI_W-1:0];
      if (wr_en_i && wr_addr_i == A_MODE) mode_o <= page_mode_e'(wr_data_i[1:0]);
      if (wr_en_i && wr_addr_i == A_VCTL) tall_o <= wr_data_i[TALL_BIT];
      if (spr_hit)     bg_last_o <= 1'b0;
      else if (bg_hit) bg_last_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < SPR_N; g++) begin : g_spr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) spr_bank_o[g] <= '0;
      else if (spr_hit && wr_addr_i[SPR_LSB-1:0] == SPR_LSB'(g))
        spr_bank_o[g] <= {hi_q, wr_data_i};
    end
  end

  for (genvar g = 0; g < BG_N; g++) begin : g_bg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bg_bank_o[g] <= '0;
      else if (bg_hit && wr_addr_i[BG_LSB-1:0] == BG_LSB'(g))
        bg_bank_o[g] <= {hi_q, wr_data_i};
    end
  end
endmodule

// File: rtl/pbg_set_sel.sv
`timescale 1ns/1ps
module pbg_set_sel
  import pbg_pkg::*;
(
  input  logic              in_frame_i,
  input  logic              tall_i,
  input  logic              bg_last_i,
  input  logic [HPOS_W-1:0] hpos_i,
  output logic              use_bg_o
);
  logic bg_phase;
  assign bg_phase = (hpos_i < HPOS_W'(SPR_PH_LO)) || (hpos_i >= HPOS_W'(SPR_PH_HI));

  // Tall sprites need both sets within one line, so phase wins in frame
  always_comb begin
    if (in_frame_i && tall_i) use_bg_o = bg_phase;
    else                      use_bg_o = bg_last_i;
  end
endmodule

// File: rtl/pbg_page_map.sv
`timescale 1ns/1ps
module pbg_page_map
  import pbg_pkg::*;
#(
  parameter int N_REGS = 8,
  parameter int FOLD_W = 13
) (
  input  page_mode_e         mode_i,
  input  logic [FETCH_W-1:0] fetch_i,
  input  logic [BANK_W-1:0]  banks_i [N_REGS],
  output logic [PHYS_W-1:0]  phys_o
);
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam logic [FETCH_W-1:0] FOLD_MASK = FETCH_W'((1 << FOLD_W) - 1);

  logic [FETCH_W-1:0] a;
  logic [IDX_W-1:0]   idx;
  logic [BANK_W-1:0]  bank;
  logic [PHYS_W-1:0]  bank_x;

  assign a      = fetch_i & FOLD_MASK;
  assign bank   = banks_i[idx];
  assign bank_x = PHYS_W'(bank);

  // Index formula is shared; truncation to IDX_W yields the reduced-set case
  always_comb begin
    unique case (mode_i)
      PG_8K: idx = IDX_W'(3'b111);
      PG_4K: idx = IDX_W'({a[12], 2'b11});
      PG_2K: idx = IDX_W'({a[12:11], 1'b1});
      default: idx = IDX_W'(a[12:10]);
    endcase
  end

  always_comb begin
    unique case (mode_i)
      PG_8K: phys_o = (bank_x << 13) | PHYS_W'(a[12:0]);
      PG_4K: phys_o = (bank_x << 12) | PHYS_W'(a[11:0]);
      PG_2K: phys_o = (bank_x << 11) | PHYS_W'(a[10:0]);
      default: phys_o = (bank_x << 10) | PHYS_W'(a[9:0]);
    endcase
  end
endmodule

// File: rtl/pattern_bank_gen.sv
`timescale 1ns/1ps
module pattern_bank_gen
  import pbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [12:0]       fetch_addr_i,
  input  logic [8:0]        hpos_i,
  input  logic              in_frame_i,
  output logic [22:0]       phys_addr_o
);
  logic [BANK_W-1:0] spr_bank [SPR_N];
  logic [BANK_W-1:0] bg_bank  [BG_N];
  page_mode_e        mode;
  logic              bg_last, tall, use_bg;
  logic [PHYS_W-1:0] spr_phys, bg_phys;

  pbg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .spr_bank_o (spr_bank),
    .bg_bank_o  (bg_bank),
    .mode_o     (mode),
    .bg_last_o  (bg_last),
    .tall_o     (tall)
  );

  pbg_set_sel u_sel (
    .in_frame_i (in_frame_i),
    .tall_i     (tall),
    .bg_last_i  (bg_last),
    .hpos_i     (hpos_i),
    .use_bg_o   (use_bg)
  );

  pbg_page_map #(.N_REGS(SPR_N), .FOLD_W(FETCH_W)) u_spr_map (
    .mode_i  (mode),
    .fetch_i (fetch_addr_i),
    .banks_i (spr_bank),
    .phys_o  (spr_phys)
  );

  pbg_page_map #(.N_REGS(BG_N), .FOLD_W(BG_FOLD_W)) u_bg_map (
    .mode_i  (mode),
    .fetch_i (fetch_addr_i),
    .banks_i (bg_bank),
    .phys_o  (bg_phys)
  );

  assign phys_addr_o = use_bg ? bg_phys : spr_phys;
endmodule

// File: rtl/pattern_bank_chk.sv
`timescale 1ns/1ps
module pattern_bank_chk
  import pbg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [15:0]       wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [12:0]       fetch_addr_i,
  input logic [8:0]        hpos_i,
  input logic              in_frame_i,
  input logic [22:0]       phys_addr_o,
  input logic              use_bg_i,
  input logic              bg_last_i,
  input logic              tall_i,
  input page_mode_e        mode_i
);
  AST_SPR_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i >= A_SPR && wr_addr_i < A_BG |=> !bg_last_i); // R9
  AST_BG_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i >= A_BG && wr_addr_i < (A_BG + 16'd4) |=> bg_last_i); // R9
  AST_SET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bg_last_i)); // R9
  AST_OUT_FRAME_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_frame_i |-> use_bg_i == bg_last_i); // R9
  AST_TALL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_i && tall_i && hpos_i >= 9'd256 && hpos_i < 9'd320 |-> !use_bg_i); // R10
  AST_SHORT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_i && !tall_i |-> use_bg_i == bg_last_i); // R11
  AST_TALL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == A_VCTL |=> tall_i == $past(wr_data_i[TALL_BIT])); // R12
  AST_MODE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == A_MODE |=> mode_i == page_mode_e'($past(wr_data_i[1:0]))); // R13
  AST_SPR_8K_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == PG_8K && !use_bg_i |-> phys_addr_o[12:0] == fetch_addr_i); // R3
  AST_BG_8K_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == PG_8K && use_bg_i |-> !phys_addr_o[12]); // R7
  AST_FINE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[9:0] == fetch_addr_i[9:0]); // R6
endmodule

bind pattern_bank_gen pattern_bank_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .fetch_addr_i (fetch_addr_i),
  .hpos_i       (hpos_i),
  .in_frame_i   (in_frame_i),
  .phys_addr_o  (phys_addr_o),
  .use_bg_i     (use_bg),
  .bg_last_i    (bg_last),
  .tall_i       (tall),
  .mode_i       (mode)
);

// File: tb/tb_pattern_bank_gen.sv
`timescale 1ns/1ps
module tb_pattern_bank_gen;
  logic        clk = 0, rst_ni = 0, wr_en = 0, in_frame = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [12:0] fetch = 0;
  logic [8:0]  hpos = 0;
  logic [22:0] phys;

  typedef struct { logic [22:0] exp; string tag; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Bench view of the programmed state
  int m_spr[8], m_bg[4], m_hi = 0, m_mode = 0, m_flag = 0, m_tall = 0;

  pattern_bank_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .fetch_addr_i(fetch), .hpos_i(hpos),
    .in_frame_i(in_frame), .phys_addr_o(phys)
  );

  always #2.5 clk = ~clk;

  function automatic longint model(int a, int hp, bit fr);
    bit bgsel;
    int f;
    if (fr && m_tall != 0) bgsel = (hp < 256) || (hp >= 320);
    else                   bgsel = (m_flag != 0);
    if (!bgsel) begin
      case (m_mode)
        0: return longint'(m_spr[7]) * 8192 + a % 8192;
        1: return longint'(m_spr[(a / 4096) * 4 + 3]) * 4096 + a % 4096;
        2: return longint'(m_spr[(a / 2048) * 2 + 1]) * 2048 + a % 2048;
        default: return longint'(m_spr[a / 1024]) * 1024 + a % 1024;
      endcase
    end
    f = a % 4096;
    case (m_mode)
      0: return longint'(m_bg[3]) * 8192 + f;
      1: return longint'(m_bg[3]) * 4096 + f;
      2: return longint'(m_bg[(f / 2048) * 2 + 1]) * 2048 + f % 2048;
      default: return longint'(m_bg[f / 1024]) * 1024 + f % 1024;
    endcase
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_addr = 16'(addr); wr_data = 8'(data);
    if (addr == 'h2000) m_tall = (data >> 5) & 1;
    if (addr == 'h5101) m_mode = data & 3;
    if (addr == 'h5130) m_hi = data & 3;
    if (addr >= 'h5120 && addr <= 'h5127) begin m_spr[addr - 'h5120] = m_hi * 256 + data; m_flag = 0; end
    if (addr >= 'h5128 && addr <= 'h512b) begin m_bg[addr - 'h5128] = m_hi * 256 + data; m_flag = 1; end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_exp(input int a, input int hp, input bit fr, input logic [22:0] e, input string tag);
    @(negedge clk);
    fetch = 13'(a); hpos = 9'(hp); in_frame = fr;
    q.push_back('{e, tag});
  endtask

  task automatic chk(input int a, input int hp, input bit fr, input string tag);
    chk_exp(a, hp, fr, 23'(model(a, hp, fr)), tag);
  endtask

  // Monitor: compare one queued item per cycle, after the edge settles
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (phys !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h (fetch=%h hpos=%0d frame=%0b)",
                   it.tag, phys, it.exp, fetch, hpos, in_frame);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (m_spr[i]) m_spr[i] = 0;
    foreach (m_bg[i])  m_bg[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    chk_exp('h1abc, 0, 0, 23'h001abc, "R1");
    chk_exp('h0000, 300, 1, 23'h000000, "R1");

    wr('h5130, 'hfe);                      // upper bits = 2, R2
    for (int i = 0; i < 8; i++) wr('h5120 + i, 'h10 + i * 3);
    wr('h5130, 1);                         // must not alter stored banks, R2
    chk_exp('h0123, 0, 0, 23'h44a123, "R2");
    chk('h0123, 0, 0, "R3");
    chk('h1fff, 0, 0, "R3");

    wr('h5101, 'hfd);                      // upper bits ignored, R13
    chk('h0400, 0, 0, "R13");
    chk('h1400, 0, 0, "R4");
    chk('h0fff, 0, 0, "R4");

    wr('h5101, 2);
    for (int k = 0; k < 4; k++) chk(k * 'h800 + 'h155, 0, 0, "R5");
    wr('h5101, 3);
    for (int k = 0; k < 8; k++) chk(k * 'h400 + 'h2a, 0, 0, "R6");

    for (int i = 0; i < 4; i++) wr('h5128 + i, 'h80 + i * 5);
    for (int m = 0; m < 2; m++) begin
      wr('h5101, m);
      chk('h0abc, 0, 0, "R7");
      chk('h1abc, 0, 0, "R7");
    end
    for (int m = 2; m < 4; m++) begin
      wr('h5101, m);
      for (int k = 0; k < 8; k++) chk(k * 'h400 + 'h11, 0, 0, "R8");
    end

    wr('h5123, 'h44);
    chk('h0c00, 0, 0, "R9");
    wr('h512b, 'h99);
    chk('h0c00, 0, 0, "R9");
    wr('h5120, 'h21);
    chk('h0000, 0, 0, "R9");

    wr('h2000, 'h20);
    chk('h0c05, 0,   1, "R10");
    chk('h0c05, 255, 1, "R10");
    chk('h0c05, 256, 1, "R10");
    chk('h0c05, 319, 1, "R10");
    chk('h0c05, 320, 1, "R10");
    chk('h0c05, 340, 1, "R10");
    chk('h0c05, 100, 0, "R9");
    wr('h5129, 'h33);
    chk('h0405, 300, 1, "R10");
    chk('h0405, 10,  1, "R10");
    chk('h0405, 300, 0, "R9");

    wr('h2000, 'hdf);
    chk('h0405, 10,  1, "R11");
    chk('h0405, 300, 1, "R11");
    wr('h5124, 7);
    chk('h1005, 10,  1, "R11");

    wr('h5131, 'hff);
    wr('h511f, 'hff);
    wr('h2001, 'h20);
    wr('h5100, 'h00);
    chk('h1005, 10,  1, "R12");
    chk('h1005, 300, 1, "R12");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule